// File: doc/BRIEF.md
# Ranked Cell Allocator with Fault Swap

This block decides, once per control period, which cells of a reconfigurable battery string sit in the series path and which are bypassed. It is given a target number of active levels, a live priority ranking that maps each rank position to a cell index, and a per-cell fault vector. Any cell can serve any level of the output staircase, so the block only has to keep the count right while favouring the best-ranked healthy cells. When the count must rise it takes the best unconnected healthy cells. When it must fall it drops the worst-ranked connected cells. Faulty cells are pulled out and replaced in the same period, and after a re-rank, outranked connected cells are swapped for better unconnected ones with no change in count.

Cells are grouped into modules of `CPM` cells, and only `CALL_BUDGET` modules may be commanded in one period. The block walks the ranking one position per clock after each period strobe. Work that does not fit in the module budget is left for later periods. At the end of the walk it publishes the new connected bitmap together with one command record per touched module, and it pulses a done flag.

Top module: `ranked_cell_allocator`

## Requirements
- R1: When the target exceeds the active count, unconnected healthy cells are connected in ascending rank position order (rank position 0 is best) until the count equals the target.
- R2: When the target is below the active count, connected cells are disconnected starting from the highest rank position (worst) until the count equals the target.
- R3: A connected cell whose fault bit is set at the strobe is disconnected in that period. If the count then falls below the target, the best-ranked unconnected healthy cell is connected in the same period. A faulty cell is never connected.
- R4: After a ranking change with an unchanged target, every connected cell that is outranked by an unconnected healthy cell is exchanged with it, best with worst, keeping the count unchanged.
- R5: A target of 0 disconnects every cell. A later nonzero target connects cells again from rank position 0 onward.
- R6: At most `CALL_BUDGET` distinct modules (module m holds cells m*CPM to m*CPM+CPM-1) change per period. Fault removals claim modules first, then count changes, then swaps. A change whose module cannot be claimed is skipped and is picked up in a later period.
- R7: Each published record k with `cmd_valid[k]` set names one touched module in `cmd_module[k*MODW +: MODW]`. It carries that module's full new pattern in `cmd_pattern[k*CPM +: CPM]`, where bit j is cell m*CPM+j (1 = connected). Valid records occupy the lowest slots, and a period with no change publishes no valid record.
- R8: `shortfall` is published as 1 when fewer healthy cells than the target existed at the strobe, in which case every reachable healthy cell is connected. Otherwise it is published as 0.
- R9: `done` is a one-cycle pulse, and `cell_conn` and the records change only in that cycle. A strobe arriving while work is in progress is ignored and sets `overrun`, which is cleared by the next accepted strobe.
- R10: After reset no cell is connected, no record is valid, and `done`, `overrun` and `shortfall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_stb | input | 1 | Starts the work of one control period |
| target_cnt | input | CW | Wanted number of connected cells |
| rank_map | input | N*IDXW | Entry r is the cell index holding rank position r |
| cell_fault | input | N | Per-cell fault flags |
| cell_conn | output | N | Published connected bitmap |
| cmd_valid | output | CALL_BUDGET | Record valid bits |
| cmd_module | output | CALL_BUDGET*MODW | Module index per record |
| cmd_pattern | output | CALL_BUDGET*CPM | New switch pattern per record |
| done | output | 1 | Period work published |
| overrun | output | 1 | A strobe arrived while busy |
| shortfall | output | 1 | Too few healthy cells for the target |

## Verification
The hardest situation to reach is the point where the module budget is already full when a count change or a swap needs a further module. Only then does the skip-and-defer behaviour and the fault-count-swap priority show. The stimulus gets there with a small four-module configuration and a target that jumps from three connected cells to all sixteen. The three untouched modules then exhaust the budget before the fourth is reached, and the following period has to finish the job. A reversed ranking with a faulty cell at the low end drives the swap walk through skipped candidates.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FAULT,
    PH_GROW,
    PH_SHRINK,
    PH_SWAP,
    PH_PUBLISH
  } phase_e;
endpackage

// File: rtl/csa_popcount.sv
module csa_popcount #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/csa_slot_tracker.sv
// Keeps the list of modules already claimed in the current period.
module csa_slot_tracker #(
  parameter int NUM_MODS = 32,
  parameter int BUDGET   = 3,
  localparam int MODW = $clog2(NUM_MODS),
  localparam int SW   = $clog2(BUDGET + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic [MODW-1:0]        qa,
  input  logic [MODW-1:0]        qb,
  input  logic                   add_a,
  input  logic                   add_b,
  output logic                   a_hit,
  output logic                   b_hit,
  output logic [SW-1:0]          used,
  output logic [BUDGET*MODW-1:0] slot_mod
);
  logic [MODW-1:0] slot_q [BUDGET];
  logic [SW-1:0]   used_q;
  logic            app_a, app_b;

  always_comb begin
    a_hit = 1'b0;
    b_hit = 1'b0;
    for (int k = 0; k < BUDGET; k++) begin
      if (SW'(k) < used_q && slot_q[k] == qa) a_hit = 1'b1;
      if (SW'(k) < used_q && slot_q[k] == qb) b_hit = 1'b1;
      slot_mod[k*MODW +: MODW] = slot_q[k];
    end
    app_a = add_a && !a_hit;
    app_b = add_b && !b_hit && !(app_a && qa == qb);
  end

  assign used = used_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      used_q <= '0;
      for (int k = 0; k < BUDGET; k++) slot_q[k] <= '0;
    end else begin
      for (int k = 0; k < BUDGET; k++) begin
        if (app_a && SW'(k) == used_q) slot_q[k] <= qa;
        else if (app_b && SW'(k) == used_q + SW'(app_a)) slot_q[k] <= qb;
      end
      used_q <= used_q + SW'(app_a) + SW'(app_b);
    end
  end
endmodule

// File: rtl/csa_cmd_pack.sv
// Builds one record per claimed module from the working bitmap.
module csa_cmd_pack #(
  parameter int CPM      = 4,
  parameter int NUM_MODS = 32,
  parameter int BUDGET   = 3,
  localparam int N    = CPM * NUM_MODS,
  localparam int MODW = $clog2(NUM_MODS),
  localparam int SW   = $clog2(BUDGET + 1)
) (
  input  logic [N-1:0]           work,
  input  logic [BUDGET*MODW-1:0] slot_mod,
  input  logic [SW-1:0]          used,
  output logic [BUDGET-1:0]      valid,
  output logic [BUDGET*CPM-1:0]  pat
);
  for (genvar k = 0; k < BUDGET; k++) begin : g_rec
    logic [MODW-1:0] m;
    assign m = slot_mod[k*MODW +: MODW];
    assign valid[k] = SW'(k) < used;
    assign pat[k*CPM +: CPM] = work[m*CPM +: CPM];
  end
endmodule

// File: rtl/ranked_cell_allocator.sv
module ranked_cell_allocator
  import csa_pkg::*;
#(
  parameter int CPM         = 4,
  parameter int NUM_MODS    = 32,
  parameter int CALL_BUDGET = 3,
  localparam int N    = CPM * NUM_MODS,
  localparam int IDXW = $clog2(N),
  localparam int CW   = $clog2(N + 1),
  localparam int MODW = $clog2(NUM_MODS),
  localparam int CSH  = $clog2(CPM),
  localparam int PW   = IDXW + 1,
  localparam int SW   = $clog2(CALL_BUDGET + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        period_stb,
  input  logic [CW-1:0]               target_cnt,
  input  logic [N*IDXW-1:0]           rank_map,
  input  logic [N-1:0]                cell_fault,
  output logic [N-1:0]                cell_conn,
  output logic [CALL_BUDGET-1:0]      cmd_valid,
  output logic [CALL_BUDGET*MODW-1:0] cmd_module,
  output logic [CALL_BUDGET*CPM-1:0]  cmd_pattern,
  output logic                        done,
  output logic                        overrun,
  output logic                        shortfall
);
  localparam logic [PW-1:0] N_P = PW'(N);

  phase_e          phase_q;
  logic [IDXW-1:0] rk_q [N];
  logic [N-1:0]    flt_q, work_q, conn_q;
  logic [CW-1:0]   tgt_q, act_q;
  logic [PW-1:0]   ptr_q, f_q, b_q, ptr_m1;
  logic            fh_q, bh_q, short_pend_q;
  logic [CALL_BUDGET-1:0]      valid_q;
  logic [CALL_BUDGET*MODW-1:0] mod_q;
  logic [CALL_BUDGET*CPM-1:0]  pat_q;
  logic            done_q, overrun_q, short_q;

  logic [IDXW-1:0] ca, cb;
  logic [MODW-1:0] qa, qb;
  logic            a_hit, b_hit, fit_a, fit_ab, tog_a, tog_b, start;
  logic [SW-1:0]   used;
  logic [SW:0]     need_sum;
  logic [CALL_BUDGET*MODW-1:0] slot_mod;
  logic [CALL_BUDGET-1:0]      pk_valid;
  logic [CALL_BUDGET*CPM-1:0]  pk_pat;
  logic [CW-1:0]   work_cnt, healthy_cnt;

  assign start = (phase_q == PH_IDLE) && period_stb;

  csa_popcount #(.W(N)) u_work_cnt (.bits(work_q), .count(work_cnt));
  csa_popcount #(.W(N)) u_health_cnt (.bits(~cell_fault), .count(healthy_cnt));

  // cell under the cursor(s) for the current phase
  always_comb begin
    ptr_m1 = ptr_q - 1'b1;
    cb = rk_q[b_q[IDXW-1:0]];
    case (phase_q)
      PH_FAULT:  ca = ptr_q[IDXW-1:0];
      PH_GROW:   ca = rk_q[ptr_q[IDXW-1:0]];
      PH_SHRINK: ca = rk_q[ptr_m1[IDXW-1:0]];
      default:   ca = rk_q[f_q[IDXW-1:0]];
    endcase
  end

  assign qa = MODW'(ca >> CSH);
  assign qb = MODW'(cb >> CSH);

  csa_slot_tracker #(.NUM_MODS(NUM_MODS), .BUDGET(CALL_BUDGET)) u_slots (
    .clk(clk), .rst(rst), .clr(start), .qa(qa), .qb(qb),
    .add_a(tog_a), .add_b(tog_b), .a_hit(a_hit), .b_hit(b_hit),
    .used(used), .slot_mod(slot_mod)
  );

  csa_cmd_pack #(.CPM(CPM), .NUM_MODS(NUM_MODS), .BUDGET(CALL_BUDGET)) u_pack (
    .work(work_q), .slot_mod(slot_mod), .used(used),
    .valid(pk_valid), .pat(pk_pat)
  );

  // decide which cursor cells flip this clock
  always_comb begin
    fit_a    = a_hit || (used < SW'(CALL_BUDGET));
    need_sum = {1'b0, used} + (SW+1)'(!a_hit) + (SW+1)'(!b_hit && qb != qa);
    fit_ab   = need_sum <= (SW+1)'(CALL_BUDGET);
    tog_a = 1'b0;
    tog_b = 1'b0;
    case (phase_q)
      PH_FAULT:  tog_a = (ptr_q != N_P) && work_q[ca] && flt_q[ca] && fit_a;
      PH_GROW:   tog_a = (ptr_q != N_P) && (act_q != tgt_q) && !work_q[ca] &&
                         !flt_q[ca] && fit_a;
      PH_SHRINK: tog_a = (ptr_q != '0) && (act_q != tgt_q) && work_q[ca] && fit_a;
      PH_SWAP: begin
        tog_a = (f_q < b_q) && fh_q && bh_q && fit_ab;
        tog_b = tog_a;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      for (int r = 0; r < N; r++) rk_q[r] <= '0;
      flt_q <= '0; work_q <= '0; conn_q <= '0;
      tgt_q <= '0; act_q <= '0; ptr_q <= '0; f_q <= '0; b_q <= '0;
      fh_q <= 1'b0; bh_q <= 1'b0; short_pend_q <= 1'b0;
      valid_q <= '0; mod_q <= '0; pat_q <= '0;
      done_q <= 1'b0; overrun_q <= 1'b0; short_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (period_stb && phase_q != PH_IDLE) overrun_q <= 1'b1;
      if (tog_a) work_q[ca] <= !work_q[ca];
      if (tog_b) work_q[cb] <= !work_q[cb];
      case (phase_q)
        PH_IDLE: if (period_stb) begin
          for (int r = 0; r < N; r++) rk_q[r] <= rank_map[r*IDXW +: IDXW];
          flt_q        <= cell_fault;
          tgt_q        <= target_cnt;
          act_q        <= work_cnt;
          short_pend_q <= healthy_cnt < target_cnt;
          ptr_q        <= '0;
          overrun_q    <= 1'b0;
          phase_q      <= PH_FAULT;
        end
        PH_FAULT: begin
          if (ptr_q == N_P) begin
            if (act_q < tgt_q) begin
              ptr_q <= '0; phase_q <= PH_GROW;
            end else if (act_q > tgt_q) begin
              ptr_q <= N_P; phase_q <= PH_SHRINK;
            end else begin
              f_q <= '0; b_q <= N_P - 1'b1; fh_q <= 1'b0; bh_q <= 1'b0;
              phase_q <= PH_SWAP;
            end
          end else begin
            ptr_q <= ptr_q + 1'b1;
            if (tog_a) act_q <= act_q - 1'b1;
          end
        end
        PH_GROW, PH_SHRINK: begin
          if ((phase_q == PH_GROW ? ptr_q == N_P : ptr_q == '0) || act_q == tgt_q) begin
            f_q <= '0; b_q <= N_P - 1'b1; fh_q <= 1'b0; bh_q <= 1'b0;
            phase_q <= PH_SWAP;
          end else if (phase_q == PH_GROW) begin
            ptr_q <= ptr_q + 1'b1;
            if (tog_a) act_q <= act_q + 1'b1;
          end else begin
            ptr_q <= ptr_m1;
            if (tog_a) act_q <= act_q - 1'b1;
          end
        end
        PH_SWAP: begin
          if (!(f_q < b_q)) phase_q <= PH_PUBLISH;
          else if (!fh_q) begin
            if (!work_q[ca] && !flt_q[ca]) fh_q <= 1'b1;
            else f_q <= f_q + 1'b1;
          end else if (!bh_q) begin
            if (work_q[cb]) bh_q <= 1'b1;
            else b_q <= b_q - 1'b1;
          end else if (fit_ab) begin
            f_q <= f_q + 1'b1; b_q <= b_q - 1'b1; fh_q <= 1'b0; bh_q <= 1'b0;
          end else if (!fit_a) begin
            f_q <= f_q + 1'b1; fh_q <= 1'b0;
          end else begin
            b_q <= b_q - 1'b1; bh_q <= 1'b0;
          end
        end
        PH_PUBLISH: begin
          conn_q  <= work_q;
          valid_q <= pk_valid;
          mod_q   <= slot_mod;
          pat_q   <= pk_pat;
          short_q <= short_pend_q;
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign cell_conn   = conn_q;
  assign cmd_valid   = valid_q;
  assign cmd_module  = mod_q;
  assign cmd_pattern = pat_q;
  assign done        = done_q;
  assign overrun     = overrun_q;
  assign shortfall   = short_q;
endmodule

// File: rtl/csa_checker.sv
module csa_checker
  import csa_pkg::*;
#(
  parameter int N    = 16,
  parameter int CPM  = 4,
  parameter int MODW = 2,
  parameter int B    = 3,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            period_stb,
  input phase_e          phase,
  input logic [CW-1:0]   tgt,
  input logic [N-1:0]    flt,
  input logic [N-1:0]    cell_conn,
  input logic [B-1:0]    cmd_valid,
  input logic [B*MODW-1:0] cmd_module,
  input logic [B*CPM-1:0]  cmd_pattern,
  input logic            done,
  input logic            overrun,
  input logic            shortfall
);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_conn_only_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(cell_conn) |-> done);

  a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
    (period_stb && phase != PH_IDLE) |=> overrun);

  a_r3_no_faulty_join: assert property (@(posedge clk) disable iff (rst)
    done |-> ((cell_conn & ~$past(cell_conn) & flt) == '0));

  a_r8_shortfall_count: assert property (@(posedge clk) disable iff (rst)
    (done && shortfall) |-> ($countones(cell_conn) < int'(tgt)));

  a_r7_valid_packed: assert property (@(posedge clk) disable iff (rst)
    $onehot0(B'(cmd_valid + 1'b1)));

  for (genvar k = 0; k < B; k++) begin : g_rec
    a_r7_pattern_matches: assert property (@(posedge clk) disable iff (rst)
      (done && cmd_valid[k]) |->
        cmd_pattern[k*CPM +: CPM] == cell_conn[cmd_module[k*MODW +: MODW]*CPM +: CPM]);
  end
endmodule

bind ranked_cell_allocator csa_checker #(
  .N(N), .CPM(CPM), .MODW(MODW), .B(CALL_BUDGET), .CW(CW)
) chk_i (
  .clk(clk), .rst(rst), .period_stb(period_stb), .phase(phase_q),
  .tgt(tgt_q), .flt(flt_q), .cell_conn(cell_conn), .cmd_valid(cmd_valid),
  .cmd_module(cmd_module), .cmd_pattern(cmd_pattern), .done(done),
  .overrun(overrun), .shortfall(shortfall)
);

// File: tb/ranked_cell_allocator_tb_top.sv
`timescale 1ns/1ps
module ranked_cell_allocator_tb_top;
  localparam int CPM = 4, MODS = 4, B = 3;
  localparam int N = CPM * MODS, IDXW = 4, CW = 5, MODW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic [CW-1:0] tgt = '0;
  logic [N*IDXW-1:0] rmap = '0;
  logic [N-1:0] flt = '0;
  logic [N-1:0] conn;
  logic [B-1:0] cv;
  logic [B*MODW-1:0] cm;
  logic [B*CPM-1:0] cp;
  logic done, ovr, sht;
  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  ranked_cell_allocator #(.CPM(CPM), .NUM_MODS(MODS), .CALL_BUDGET(B)) dut_i (
    .clk(clk), .rst(rst), .period_stb(stb), .target_cnt(tgt), .rank_map(rmap),
    .cell_fault(flt), .cell_conn(conn), .cmd_valid(cv), .cmd_module(cm),
    .cmd_pattern(cp), .done(done), .overrun(ovr), .shortfall(sht)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // {found, pattern} of the record for module m
  function automatic logic [4:0] rec(input int m);
    for (int k = 0; k < B; k++)
      if (cv[k] && cm[k*MODW +: MODW] == MODW'(m)) return {1'b1, cp[k*CPM +: CPM]};
    return 5'h00;
  endfunction

  task automatic set_rank(input bit rev);
    for (int r = 0; r < N; r++) rmap[r*IDXW +: IDXW] = rev ? IDXW'(N - 1 - r) : IDXW'(r);
  endtask

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin
        checks++; errs++;
        $display("FAIL watchdog: no done within 5000 cycles");
        finish_up();
      end
    end
  endtask

  task automatic run_period();
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    wait_done();
  endtask

  task automatic t_reset();
    chk("R10 conn", conn, 0);
    chk("R10 valid", cv, 0);
    chk("R10 flags", {done, ovr, sht}, 0);
  endtask

  task automatic t_grow();
    set_rank(0); flt = '0; tgt = 6;
    run_period();
    chk("R1 grow conn", conn, 32'h003F);
    chk("R7 grow records", $countones(cv), 2);
    chk("R7 mod0 pattern", rec(0), 5'h1F);
    chk("R7 mod1 pattern", rec(1), 5'h13);
    chk("R8 no shortfall", sht, 0);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_shrink();
    tgt = 3;
    run_period();
    chk("R2 shrink conn", conn, 32'h0007);
    chk("R2 mod1 cleared", rec(1), 5'h10);
    chk("R2 mod0 pattern", rec(0), 5'h17);
  endtask

  task automatic t_fault();
    flt = 16'h0002; tgt = 3;
    run_period();
    chk("R3 fault swap conn", conn, 32'h000D);
    chk("R3 single record", $countones(cv), 1);
    chk("R3 mod0 pattern", rec(0), 5'h1D);
  endtask

  task automatic t_rerank();
    set_rank(1);
    run_period();
    chk("R4 swap conn", conn, 32'hE000);
    chk("R4 mod3 pattern", rec(3), 5'h1E);
    chk("R4 mod0 pattern", rec(0), 5'h10);
  endtask

  task automatic t_budget();
    set_rank(0); flt = '0; tgt = 16;
    run_period();
    chk("R6 budget conn", conn, 32'hEFFF);
    chk("R6 three records", cv, 3'b111);
    chk("R6 mod3 untouched", rec(3), 5'h00);
    chk("R6 mod2 pattern", rec(2), 5'h1F);
    run_period();
    chk("R6 deferred conn", conn, 32'hFFFF);
    chk("R6 deferred record", rec(3), 5'h1F);
  endtask

  task automatic t_shortfall();
    flt = 16'h0003; tgt = 16;
    run_period();
    chk("R8 shortfall conn", conn, 32'hFFFC);
    chk("R8 shortfall flag", sht, 1);
    chk("R3 mod0 after faults", rec(0), 5'h1C);
  endtask

  task automatic t_zero();
    tgt = 0;
    run_period();
    chk("R5 R6 zero first period", conn, 32'h000C);
    chk("R8 flag cleared", sht, 0);
    run_period();
    chk("R5 zero all bypassed", conn, 32'h0000);
    chk("R5 zero record", rec(0), 5'h10);
  endtask

  task automatic t_reconnect();
    flt = '0; set_rank(1); tgt = 2;
    run_period();
    chk("R5 reconnect order", conn, 32'hC000);
    chk("R5 reconnect record", rec(3), 5'h1C);
  endtask

  task automatic t_overrun();
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    repeat (4) @(negedge clk);
    stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    wait_done();
    chk("R9 overrun set", ovr, 1);
    chk("R7 no change no record", cv, 0);
    chk("R9 conn kept", conn, 32'hC000);
    run_period();
    chk("R9 overrun cleared", ovr, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_grow();
    t_shrink();
    t_fault();
    t_rerank();
    t_budget();
    t_shortfall();
    t_zero();
    t_reconnect();
    t_overrun();
    finish_up();
  end
endmodule